// File: doc/BRIEF.md
# Banked Voice Register File with Indirect Access

This block holds the control words of up to 32 synthesizer voices, with sixteen 16-bit slots per voice, plus two global byte registers: an active-voice count and a chip-run control byte. Software never addresses the storage directly. It first writes a voice number into a voice-select register and an operation code into a function-select register. It then moves data through a data window. The window is one 16-bit port, or two byte ports that each reach one half of the selected word.

The function code chooses the target of a data access and its direction. A separate band of codes is used for writing a voice slot and for reading it back. Byte-wide writes merge into the addressed word and leave the other half untouched. Voice-slot writes are refused while the run bit of the control byte is low, so a host that holds the synthesizer stopped cannot disturb its voice state. Every read result is registered and appears on the read-data output one clock after the request.

Top module: `voice_regbank`

## Requirements
- R1: After the reset input is released, every voice word, the voice-select and function-select registers, the voice count, the control byte and `rdata` are all zero.
- R2: The addressed voice word is number voice*16 + slot. The voice is bits 4:0 of voice-select and the slot is bits 3:0 of function-select. Codes 0x00 to 0x0D write a word, and codes 0x80 to 0x8D read the same word. Higher voice-select bits are ignored.
- R3: A voice-word write has no effect while bit 0 of the control byte is 0.
- R4: The `wide`=1 flag on either data port writes the whole word. A byte write (`wide`=0) to the low data port (`addr`=2) places `wdata[7:0]` into bits 7:0. A byte write to the high data port (`addr`=3) places `wdata[7:0]` into bits 15:8. The other byte keeps its value.
- R5: A wide read returns the whole word. A byte read from the high port returns bits 15:8 of the word zero-extended, and a byte read from the low port returns bits 7:0 zero-extended.
- R6: Code 0x0E writes `wdata[7:0]` into the voice count, and code 0x8E reads it back zero-extended on either data port.
- R7: A data-port read with any code other than 0x80 to 0x8E or 0xCC returns 0xFFFF. This includes the write codes 0x00 to 0x0E.
- R8: Code 0x4C writes `wdata[7:0]` into the control byte, and code 0xCC reads it back. If the written bit 0 is 0, the voice count becomes 0xCD and control bits 2:1 are cleared.
- R9: A read at `addr`=0 returns voice-select and a read at `addr`=1 returns function-select, both zero-extended. Writes at these addresses load `wdata[7:0]`.
- R10: `rdata` changes only on the clock edge that captures `rd_en`. It holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 2 | 0 voice-select, 1 function-select, 2 low data, 3 high data |
| wide | input | 1 | 1 selects a 16-bit data access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
A write changes state on the edge that samples it, so a read issued in the next cycle already sees the new value. A read result is due on `rdata` one edge after `rd_en` is sampled. The bench drives on the falling edge and samples on the following falling edge, half a cycle after the capturing edge. A behavioural model advances on the same edges and is compared on every falling edge, so a result that comes one cycle early or late, or a change when no read was requested, shows up as a mismatch.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PORT_VSEL = 2'd0,
    PORT_FSEL = 2'd1,
    PORT_DLO  = 2'd2,
    PORT_DHI  = 2'd3
  } port_e;

  typedef enum logic [2:0] {
    SRC_VSEL,
    SRC_FSEL,
    SRC_WORD,
    SRC_COUNT,
    SRC_CTL,
    SRC_NONE
  } rd_src_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } lanes_t;

  localparam logic [7:0] FN_COUNT_WR = 8'h0E;
  localparam logic [7:0] FN_CTL_WR   = 8'h4C;
  localparam logic [7:0] FN_COUNT_RD = 8'h8E;
  localparam logic [7:0] FN_CTL_RD   = 8'hCC;
  localparam logic [7:0] COUNT_RELOAD = 8'hCD;
endpackage

// File: rtl/vrb_decode.sv
module vrb_decode
  import vrb_pkg::*;
#(
  parameter int VOICE_FUNCS = 14
) (
  input  logic [7:0]        fsel,
  input  logic [1:0]        addr,
  input  logic              wide,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic              word_we,
  output lanes_t            lanes,
  output logic [WORD_W-1:0] wword,
  output logic              count_we,
  output logic              ctl_we,
  output rd_src_e           rd_src
);
  logic data_port;
  logic wr_code, rd_code;

  always_comb begin
    data_port = addr[1];
    wr_code   = fsel < 8'(VOICE_FUNCS);
    rd_code   = fsel[7] && (fsel[6:0] < 7'(VOICE_FUNCS));

    lanes.lo = wide || (port_e'(addr) == PORT_DLO);
    lanes.hi = wide || (port_e'(addr) == PORT_DHI);
    wword    = wide ? wdata : {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};

    word_we  = wr_en && data_port && wr_code;
    count_we = wr_en && data_port && (fsel == FN_COUNT_WR);
    ctl_we   = wr_en && data_port && (fsel == FN_CTL_WR);

    unique case (port_e'(addr))
      PORT_VSEL: rd_src = SRC_VSEL;
      PORT_FSEL: rd_src = SRC_FSEL;
      default: begin
        if (rd_code)                   rd_src = SRC_WORD;
        else if (fsel == FN_COUNT_RD)  rd_src = SRC_COUNT;
        else if (fsel == FN_CTL_RD)    rd_src = SRC_CTL;
        else                           rd_src = SRC_NONE;
      end
    endcase
  end
endmodule

// File: rtl/vrb_store.sv
module vrb_store
  import vrb_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  lanes_t            lanes,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic              hit;
    logic [WORD_W-1:0] word_q;

    assign hit = we && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        if (hit && lanes.lo) word_q[BYTE_W-1:0]      <= wword[BYTE_W-1:0];
        if (hit && lanes.hi) word_q[WORD_W-1:BYTE_W] <= wword[WORD_W-1:BYTE_W];
      end
    end

    assign mem[g] = word_q;
  end

  assign rword = mem[idx];
endmodule

// File: rtl/vrb_globals.sv
module vrb_globals
  import vrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_we,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] count_q,
  output logic [BYTE_W-1:0] ctl_q
);
  logic [BYTE_W-1:0] count_d, ctl_d;

  always_comb begin
    count_d = count_q;
    ctl_d   = ctl_q;
    if (ctl_we) begin
      ctl_d = wbyte;
      if (!wbyte[0]) begin
        ctl_d[2:1] = 2'b00;
        count_d    = COUNT_RELOAD;
      end
    end else if (count_we) begin
      count_d = wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ctl_q   <= '0;
    end else begin
      count_q <= count_d;
      ctl_q   <= ctl_d;
    end
  end
endmodule

// File: rtl/voice_regbank.sv
module voice_regbank
  import vrb_pkg::*;
#(
  parameter int NUM_VOICES  = 32,
  parameter int FUNC_SLOTS  = 16,
  parameter int VOICE_FUNCS = 14,
  localparam int VOICE_W = $clog2(NUM_VOICES),
  localparam int FUNC_W  = $clog2(FUNC_SLOTS),
  localparam int DEPTH   = NUM_VOICES * FUNC_SLOTS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic        wide,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [7:0]        vsel_q, vsel_d, fsel_q, fsel_d;
  logic [WORD_W-1:0] rdata_d;
  logic              word_we, count_we, ctl_we;
  lanes_t            lanes;
  logic [WORD_W-1:0] wword, cur_word;
  rd_src_e           rd_src;
  logic [BYTE_W-1:0] count_q, ctl_q;
  logic [VOICE_W+FUNC_W-1:0] word_idx;

  assign word_idx = {vsel_q[VOICE_W-1:0], fsel_q[FUNC_W-1:0]};

  vrb_decode #(.VOICE_FUNCS(VOICE_FUNCS)) u_decode (
    .fsel(fsel_q), .addr(addr), .wide(wide), .wr_en(wr_en), .wdata(wdata),
    .word_we(word_we), .lanes(lanes), .wword(wword),
    .count_we(count_we), .ctl_we(ctl_we), .rd_src(rd_src)
  );

  vrb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .we(word_we && ctl_q[0]), .lanes(lanes),
    .idx(word_idx), .wword(wword), .rword(cur_word)
  );

  vrb_globals u_globals (
    .clk(clk), .rst_n(rst_sync_n), .count_we(count_we), .ctl_we(ctl_we),
    .wbyte(wdata[BYTE_W-1:0]), .count_q(count_q), .ctl_q(ctl_q)
  );

  always_comb begin
    vsel_d = vsel_q;
    fsel_d = fsel_q;
    if (wr_en && port_e'(addr) == PORT_VSEL) vsel_d = wdata[7:0];
    if (wr_en && port_e'(addr) == PORT_FSEL) fsel_d = wdata[7:0];

    rdata_d = rdata;
    if (rd_en) begin
      unique case (rd_src)
        SRC_VSEL:  rdata_d = {8'h00, vsel_q};
        SRC_FSEL:  rdata_d = {8'h00, fsel_q};
        SRC_COUNT: rdata_d = {8'h00, count_q};
        SRC_CTL:   rdata_d = {8'h00, ctl_q};
        SRC_WORD: begin
          if (wide)                               rdata_d = cur_word;
          else if (port_e'(addr) == PORT_DHI)     rdata_d = {8'h00, cur_word[15:8]};
          else                                    rdata_d = {8'h00, cur_word[7:0]};
        end
        default:   rdata_d = 16'hFFFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vsel_q <= '0;
      fsel_q <= '0;
      rdata  <= '0;
    end else begin
      vsel_q <= vsel_d;
      fsel_q <= fsel_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/vrb_checker.sv
module vrb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic        wide,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [7:0]  vsel,
  input logic [7:0]  fsel,
  input logic [15:0] sel_word,
  input logic [7:0]  vcount,
  input logic [7:0]  ctl
);
  // R3: voice-slot write while stopped leaves the word as it was
  p_stopped_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1] && fsel < 8'd14 && !ctl[0]) |=> $stable(sel_word));

  // R4: low byte write keeps the high byte
  p_low_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !wide && fsel < 8'd14 && ctl[0]) |=>
      (sel_word[15:8] == $past(sel_word[15:8]) && sel_word[7:0] == $past(wdata[7:0])));

  // R4: high byte write keeps the low byte
  p_high_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wide && fsel < 8'd14 && ctl[0]) |=>
      (sel_word[7:0] == $past(sel_word[7:0]) && sel_word[15:8] == $past(wdata[7:0])));

  // R7: unmapped read code gives all ones
  p_unmapped_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1] && !(fsel[7] && fsel[6:0] <= 7'h0E) && fsel != 8'hCC) |=>
      (rdata == 16'hFFFF));

  // R8: control write with run bit low reloads the count
  p_ctl_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1] && fsel == 8'h4C && !wdata[0]) |=>
      (vcount == 8'hCD && ctl[2:0] == 3'b000));

  // R9: voice-select read-back
  p_vsel_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !(wr_en && addr == 2'd0)) |=> (rdata == {8'h00, $past(vsel)}));

  // R10: output holds without a read
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind voice_regbank vrb_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wide(wide), .wdata(wdata), .rdata(rdata), .vsel(vsel_q), .fsel(fsel_q),
  .sel_word(cur_word), .vcount(count_q), .ctl(ctl_q)
);

// File: tb/tb_voice_regbank.sv
module tb_voice_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wide = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  voice_regbank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wide(wide), .wdata(wdata), .rdata(rdata));

  always #2 clk = ~clk;

  // behavioural reference
  int m_mem [512];
  int m_vsel, m_fsel, m_cnt, m_ctl, m_rd;
  int m_live;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_vsel = 0; m_fsel = 0; m_cnt = 0; m_ctl = 0; m_rd = 0; m_live = 0;
    end else begin
      int w, d;
      m_live = m_live + 1;
      if (m_live > 2) begin
        w = (m_vsel % 32) * 16 + (m_fsel % 16);
        d = int'(wdata);
        if (rd_en) begin
          if (addr == 0) m_rd = m_vsel;
          else if (addr == 1) m_rd = m_fsel;
          else if (m_fsel >= 'h80 && m_fsel <= 'h8D)
            m_rd = wide ? m_mem[w] : (addr == 3 ? m_mem[w] / 256 : m_mem[w] % 256);
          else if (m_fsel == 'h8E) m_rd = m_cnt;
          else if (m_fsel == 'hCC) m_rd = m_ctl;
          else m_rd = 'hFFFF;
        end
        if (wr_en) begin
          if (addr == 0) m_vsel = d % 256;
          else if (addr == 1) m_fsel = d % 256;
          else if (m_fsel <= 13) begin
            if (m_ctl % 2 == 1) begin
              if (wide) m_mem[w] = d;
              else if (addr == 2) m_mem[w] = (m_mem[w] / 256) * 256 + d % 256;
              else m_mem[w] = (d % 256) * 256 + m_mem[w] % 256;
            end
          end else if (m_fsel == 14) m_cnt = d % 256;
          else if (m_fsel == 'h4C) begin
            m_ctl = d % 256;
            if (d % 2 == 0) begin m_ctl = m_ctl & 'hF9; m_cnt = 'hCD; end
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (int'(rdata) != m_rd) begin
      n_bad++;
      $display("FAIL %s model compare: rdata=%h expected=%h", cur_req, rdata, m_rd[15:0]);
    end
  end

  task automatic acc(input bit w, input bit r, input logic [1:0] a, input bit wd, input logic [15:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wide = wd; wdata = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input bit wd, input logic [15:0] d);
    acc(1, 0, a, wd, d);
  endtask

  task automatic rd_chk(input logic [1:0] a, input bit wd, input logic [15:0] exp, input string req);
    acc(0, 1, a, wd, 16'h0);
    @(negedge clk); #0.5;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read addr=%0d: rdata=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: rdata=%h expected=finish", rdata);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    cur_req = "R1";
    rd_chk(2'd0, 0, 16'h0000, "R1");
    rd_chk(2'd2, 1, 16'hFFFF, "R1");        // fsel 0x00 is a write code
    wr(2'd1, 0, 16'h0080);
    rd_chk(2'd2, 1, 16'h0000, "R1");
    rd_chk(2'd3, 1, 16'h0000, "R1");

    cur_req = "R3";                          // stopped: writes refused
    wr(2'd1, 0, 16'h0003); wr(2'd0, 0, 16'h0005);
    wr(2'd2, 1, 16'hDEAD);
    wr(2'd1, 0, 16'h0083);
    rd_chk(2'd2, 1, 16'h0000, "R3");

    cur_req = "R8";
    wr(2'd1, 0, 16'h004C); wr(2'd2, 1, 16'h0007);
    wr(2'd1, 0, 16'h00CC);
    rd_chk(2'd2, 1, 16'h0007, "R8");

    cur_req = "R2";
    wr(2'd1, 0, 16'h0003); wr(2'd2, 1, 16'hBEEF);
    wr(2'd1, 0, 16'h0083);
    rd_chk(2'd2, 1, 16'hBEEF, "R2");
    wr(2'd0, 0, 16'h0025);                   // upper bits dropped: voice 5
    rd_chk(2'd3, 1, 16'hBEEF, "R2");
    wr(2'd0, 0, 16'h001F); wr(2'd1, 0, 16'h000D); wr(2'd2, 1, 16'h1234);
    wr(2'd1, 0, 16'h008D);
    rd_chk(2'd2, 1, 16'h1234, "R2");
    wr(2'd0, 0, 16'h0000);
    rd_chk(2'd2, 1, 16'h0000, "R2");         // voice 0 slot 13 untouched

    cur_req = "R4";
    wr(2'd0, 0, 16'h0005); wr(2'd1, 0, 16'h0003);
    wr(2'd2, 0, 16'h77AA);
    wr(2'd3, 0, 16'h6655);
    wr(2'd1, 0, 16'h0083);
    rd_chk(2'd2, 1, 16'h55AA, "R4");

    cur_req = "R5";
    rd_chk(2'd2, 0, 16'h00AA, "R5");
    rd_chk(2'd3, 0, 16'h0055, "R5");

    cur_req = "R6";
    wr(2'd1, 0, 16'h000E); wr(2'd3, 0, 16'h0117);
    wr(2'd1, 0, 16'h008E);
    rd_chk(2'd3, 0, 16'h0017, "R6");

    cur_req = "R7";
    wr(2'd1, 0, 16'h0003);
    rd_chk(2'd2, 1, 16'hFFFF, "R7");
    wr(2'd1, 0, 16'h0045);
    rd_chk(2'd3, 0, 16'hFFFF, "R7");
    wr(2'd1, 0, 16'h008F);
    rd_chk(2'd2, 1, 16'hFFFF, "R7");

    cur_req = "R8";
    wr(2'd1, 0, 16'h004C); wr(2'd2, 1, 16'h00F6);
    wr(2'd1, 0, 16'h00CC);
    rd_chk(2'd2, 1, 16'h00F0, "R8");
    wr(2'd1, 0, 16'h008E);
    rd_chk(2'd2, 1, 16'h00CD, "R8");
    cur_req = "R3";
    wr(2'd1, 0, 16'h0003); wr(2'd2, 1, 16'h0BAD);
    wr(2'd1, 0, 16'h0083);
    rd_chk(2'd2, 1, 16'h55AA, "R3");

    cur_req = "R9";
    rd_chk(2'd1, 0, 16'h0083, "R9");
    rd_chk(2'd0, 0, 16'h0005, "R9");

    cur_req = "R10";
    repeat (5) @(posedge clk);
    @(negedge clk); #0.5;
    n_cmp++;
    if (rdata !== 16'h0005) begin
      n_bad++;
      $display("FAIL R10 hold: rdata=%h expected=%h", rdata, 16'h0005);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule